// File: doc/BRIEF.md
# BCD Clock-Calendar Counter

This block keeps time of day and the calendar as eight packed-BCD bytes: hundredths of a second, seconds, minutes, hours, day of week, date, month and a two-digit year. A base tick enable, `tick_en`, drives it. Every `TICK_DIV` base ticks the hundredths byte advances one step, and carries ripple up through the other bytes in the same clock edge. Hours run in 24-hour form or in 12-hour form with a PM flag. The date rolls over at the last day of each month, and February gets a leap day whenever the two-digit year is a multiple of four.

A register-access controller writes a complete 64-bit image through the load port. To read, it raises `snap_req` at the start of a transfer and then shifts out the held `snap_data` at its own pace. Carries that happen during that shift do not change the held value. The day byte also holds two control bits. One stops the clock when set. The other is a reset-mask flag, which the block only passes out to the controller.

The image layout is fixed, because the controller shifts it out bit 0 first. Byte k sits at bits 8k+7..8k, in this order: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. The hours byte uses bit 7 to select 12-hour mode when set, bit 5 as the PM flag (12-hour mode) or the tens-of-hours bit worth 20 (24-hour mode), and bits 4..0 for the rest of the hour. The day byte uses bits 2..0 for the day of week (1..7), bit 4 for the reset mask and bit 5 for the stop bit (0 = running). Back-pressure on the load port is simple: `load_ready` is high whenever the block is out of reset, and an image is taken on every cycle where `load_valid` and `load_ready` are both high. The snapshot port has no back-pressure. Its data stays valid until the next request.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: Reset leaves the image 64'h0001012100000000, which is 00:00:00.00 in 24-hour mode, day 1, date 01, month 01, year 00, with the clock stopped (day bit 5 = 1). After reset, `osc_run` and `rst_mask` are 0 and `load_ready` is 1.
- R2: While the clock runs, the hundredths byte advances once for every `TICK_DIV` cycles with `tick_en` high. Hundredths roll from 99 to 00 and carry into seconds. Seconds and minutes roll from 59 to 00 and carry onward.
- R3: In 24-hour mode (hours bit 7 = 0), 23 is followed by 00, and that rollover advances the day of week and the date.
- R4: In 12-hour mode (hours bit 7 = 1), 11 is followed by 12 and bit 5 toggles. 12 is followed by 01 and bit 5 is unchanged. Only the step from 11 PM to 12 AM advances the day.
- R5: The date rolls to 01 and the month advances after 30 in months 04, 06, 09 and 11, and after 31 in months 01, 03, 05, 07, 08, 10 and 12.
- R6: In month 02, the date rolls after 29 when the BCD year is divisible by 4 (00 counts), and after 28 otherwise.
- R7: Day of week goes from 7 to 1. Month goes from 12 to 01 and advances the year. Year goes from 99 to 00.
- R8: When day bit 5 is 1, ticks change nothing and `osc_run` is 0. When the bit is 0, `osc_run` is 1.
- R9: `rst_mask` equals day bit 4. Day bits 7..3 are kept unchanged when the day of week advances.
- R10: On a cycle where `load_valid` and `load_ready` are both high, the next image equals `load_data`, a tick in that same cycle is dropped, and the tick-division phase restarts at zero.
- R11: `snap_valid` pulses in the cycle after `snap_req`. `snap_data` then holds the image as it stood at the request edge, before any load or step in that edge, and does not change until the next request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Base tick enable; `TICK_DIV` ticks make one hundredth |
| load_valid | input | 1 | Load image offered |
| load_ready | output | 1 | Load image can be taken (high out of reset) |
| load_data | input | 64 | Full register image to write |
| snap_req | input | 1 | Capture a snapshot at this edge |
| snap_valid | output | 1 | One-cycle pulse: the snapshot has been updated |
| snap_data | output | 64 | Held snapshot image |
| osc_run | output | 1 | High when the clock is running (inverse of day bit 5) |
| rst_mask | output | 1 | Reset-mask control, day bit 4 |

## Verification
The bench runs the clock across several boundaries: one that stays inside a second, one at midnight on the last day of a year in 24-hour mode, and the noon, 1 o'clock and midnight steps in 12-hour mode. Each one shows whether a carry stops at the right byte. Month-end cases cover 30-day, 31-day and February dates in leap and common years, which separates the month-length table from the leap rule. Separate patterns check the stop bit, reloading part-way through a tick division (to see the phase restart), and snapshot holding while the clock keeps running.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] date;
    logic [7:0] day;
    logic [7:0] hours;
    logic [7:0] minutes;
    logic [7:0] seconds;
    logic [7:0] hund;
  } rtc_image_t;

  localparam int DAY_MASK_BIT = 4;
  localparam int DAY_STOP_BIT = 5;
  localparam int HR_MODE_BIT  = 7;
  localparam int HR_PM_BIT    = 5;

  // One BCD step of a two-digit value (no wrap handling).
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // BCD year divisible by four: even tens with ones 0/4/8, odd tens with 2/6.
  function automatic logic is_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic run,
  input  logic restart,
  output logic step
);
  generate
    if (TICK_DIV <= 1) begin : g_direct
      assign step = tick_en && run && !restart;
    end else begin : g_count
      localparam int CW = $clog2(TICK_DIV);
      localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
      logic [CW-1:0] phase_q;

      always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
          phase_q <= '0;
        end else if (tick_en && run) begin
          phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
      end

      assign step = tick_en && run && !restart && (phase_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/rtc_tod.sv
module rtc_tod
  import rtc_pkg::*;
(
  input  logic       step,
  input  logic [7:0] hund,
  input  logic [7:0] seconds,
  input  logic [7:0] minutes,
  input  logic [7:0] hours,
  output logic [7:0] hund_nx,
  output logic [7:0] seconds_nx,
  output logic [7:0] minutes_nx,
  output logic [7:0] hours_nx,
  output logic       day_carry
);
  logic c_hund, c_sec, c_min;
  logic [7:0] h24, h12, inc24, inc12;

  always_comb begin
    hund_nx    = hund;
    seconds_nx = seconds;
    minutes_nx = minutes;
    hours_nx   = hours;
    day_carry  = 1'b0;
    c_hund     = 1'b0;
    c_sec      = 1'b0;
    c_min      = 1'b0;
    h24        = {2'b00, hours[5:0]};
    h12        = {3'b000, hours[4:0]};
    inc24      = bcd_inc(h24);
    inc12      = bcd_inc(h12);

    if (step) begin
      if (hund >= 8'h99) begin
        hund_nx = 8'h00;
        c_hund  = 1'b1;
      end else begin
        hund_nx = bcd_inc(hund);
      end
    end

    if (c_hund) begin
      if (seconds >= 8'h59) begin
        seconds_nx = 8'h00;
        c_sec      = 1'b1;
      end else begin
        seconds_nx = bcd_inc(seconds);
      end
    end

    if (c_sec) begin
      if (minutes >= 8'h59) begin
        minutes_nx = 8'h00;
        c_min      = 1'b1;
      end else begin
        minutes_nx = bcd_inc(minutes);
      end
    end

    if (c_min) begin
      if (hours[HR_MODE_BIT]) begin
        if (h12 == 8'h11) begin
          hours_nx  = {hours[7:6], ~hours[HR_PM_BIT], 5'h12};
          day_carry = hours[HR_PM_BIT];
        end else if (h12 >= 8'h12) begin
          hours_nx = {hours[7:5], 5'h01};
        end else begin
          hours_nx = {hours[7:5], inc12[4:0]};
        end
      end else begin
        if (h24 >= 8'h23) begin
          hours_nx  = {hours[7:6], 6'h00};
          day_carry = 1'b1;
        end else begin
          hours_nx = {hours[7:6], inc24[5:0]};
        end
      end
    end
  end
endmodule

// File: rtl/rtc_cal.sv
module rtc_cal
  import rtc_pkg::*;
(
  input  logic       day_carry,
  input  logic [7:0] day,
  input  logic [7:0] date,
  input  logic [7:0] month,
  input  logic [7:0] year,
  output logic [7:0] day_nx,
  output logic [7:0] date_nx,
  output logic [7:0] month_nx,
  output logic [7:0] year_nx
);
  logic c_date, c_month;
  logic [7:0] last;

  always_comb begin
    day_nx   = day;
    date_nx  = date;
    month_nx = month;
    year_nx  = year;
    c_date   = 1'b0;
    c_month  = 1'b0;
    last     = month_last(month, year);

    if (day_carry) begin
      day_nx = {day[7:3], (day[2:0] >= 3'd7) ? 3'd1 : day[2:0] + 3'd1};
      if (date >= last) begin
        date_nx = 8'h01;
        c_date  = 1'b1;
      end else begin
        date_nx = bcd_inc(date);
      end
    end

    if (c_date) begin
      if (month >= 8'h12) begin
        month_nx = 8'h01;
        c_month  = 1'b1;
      end else begin
        month_nx = bcd_inc(month);
      end
    end

    if (c_month) begin
      year_nx = (year >= 8'h99) ? 8'h00 : bcd_inc(year);
    end
  end
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_pkg::*;
#(
  parameter int TICK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        load_valid,
  output logic        load_ready,
  input  logic [63:0] load_data,
  input  logic        snap_req,
  output logic        snap_valid,
  output logic [63:0] snap_data,
  output logic        osc_run,
  output logic        rst_mask
);
  localparam rtc_image_t RESET_IMG = 64'h0001_0121_0000_0000;

  rtc_image_t cur_q, nxt, snap_q;
  logic       snap_valid_q;
  logic       load_fire, step, day_carry;

  assign load_ready = rst_n;
  assign load_fire  = load_valid && load_ready;
  assign osc_run    = !cur_q.day[DAY_STOP_BIT];
  assign rst_mask   = cur_q.day[DAY_MASK_BIT];

  rtc_prescale #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .run     (osc_run),
    .restart (load_fire),
    .step    (step)
  );

  rtc_tod u_tod (
    .step       (step),
    .hund       (cur_q.hund),
    .seconds    (cur_q.seconds),
    .minutes    (cur_q.minutes),
    .hours      (cur_q.hours),
    .hund_nx    (nxt.hund),
    .seconds_nx (nxt.seconds),
    .minutes_nx (nxt.minutes),
    .hours_nx   (nxt.hours),
    .day_carry  (day_carry)
  );

  rtc_cal u_cal (
    .day_carry (day_carry),
    .day       (cur_q.day),
    .date      (cur_q.date),
    .month     (cur_q.month),
    .year      (cur_q.year),
    .day_nx    (nxt.day),
    .date_nx   (nxt.date),
    .month_nx  (nxt.month),
    .year_nx   (nxt.year)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= RESET_IMG;
    end else if (load_fire) begin
      cur_q <= load_data;
    end else if (step) begin
      cur_q <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q       <= '0;
      snap_valid_q <= 1'b0;
    end else begin
      snap_valid_q <= snap_req;
      if (snap_req) snap_q <= cur_q;
    end
  end

  assign snap_valid = snap_valid_q;
  assign snap_data  = snap_q;
endmodule

// File: rtl/rtc_bcd_calendar_chk.sv
module rtc_bcd_calendar_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        load_valid,
  input logic        load_ready,
  input logic [63:0] load_data,
  input logic        snap_req,
  input logic        snap_valid,
  input logic [63:0] snap_data,
  input logic        osc_run,
  input logic        step,
  input logic [63:0] cur
);
  logic fire;
  assign fire = load_valid && load_ready;

  assert_load_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> cur == $past(load_data));

  assert_step_needs_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> osc_run);

  assert_frozen_when_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_run && !fire) |=> $stable(cur));

  assert_hund_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !fire) |=> cur[7:0] != $past(cur[7:0]));

  assert_snap_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    snap_req |=> snap_valid);

  assert_snap_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_req |=> !snap_valid);

  assert_snap_value_R11: assert property (@(posedge clk) disable iff (!rst_n)
    snap_req |=> snap_data == $past(cur));

  assert_snap_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_req |=> $stable(snap_data));
endmodule

bind rtc_bcd_calendar rtc_bcd_calendar_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_valid (load_valid),
  .load_ready (load_ready),
  .load_data  (load_data),
  .snap_req   (snap_req),
  .snap_valid (snap_valid),
  .snap_data  (snap_data),
  .osc_run    (osc_run),
  .step       (step),
  .cur        (cur_q)
);

// File: tb/tb_rtc_bcd_calendar.sv
module tb_rtc_bcd_calendar;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        load_valid = 1'b0;
  logic        load_ready;
  logic [63:0] load_data = '0;
  logic        snap_req = 1'b0;
  logic        snap_valid;
  logic [63:0] snap_data;
  logic        osc_run;
  logic        rst_mask;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [63:0] model;
  int          phase;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic [63:0] last_snap;

  always #10 clk = ~clk;

  rtc_bcd_calendar #(.TICK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .load_valid(load_valid), .load_ready(load_ready), .load_data(load_data),
    .snap_req(snap_req), .snap_valid(snap_valid), .snap_data(snap_data),
    .osc_run(osc_run), .rst_mask(rst_mask)
  );

  function automatic int unb(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] tob(int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int days_in(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  // Reference model of one hundredth step, written from the requirements.
  function automatic logic [63:0] ref_step(logic [63:0] img);
    int hd, sc, mn, hr, dw, dt, mo, yr;
    logic pm, m12, c;
    logic [7:0] h, d, hb;
    hd = unb(img[7:0]); sc = unb(img[15:8]); mn = unb(img[23:16]);
    h = img[31:24]; d = img[39:32];
    dt = unb(img[47:40]); mo = unb(img[55:48]); yr = unb(img[63:56]);
    m12 = h[7]; pm = h[5];
    hr = m12 ? unb({3'b000, h[4:0]}) : unb({2'b00, h[5:0]});
    dw = int'(d[2:0]);
    c = 0;
    hd++;
    if (hd == 100) begin hd = 0; sc++; end
    if (sc == 60) begin sc = 0; mn++; end
    if (mn == 60) begin
      mn = 0;
      if (m12) begin
        if (hr == 11) begin hr = 12; c = pm; pm = ~pm; end
        else if (hr == 12) hr = 1;
        else hr++;
      end else begin
        hr++;
        if (hr == 24) begin hr = 0; c = 1; end
      end
    end
    if (c) begin
      dw = (dw == 7) ? 1 : dw + 1;
      dt++;
      if (dt > days_in(mo, yr)) begin
        dt = 1; mo++;
        if (mo == 13) begin mo = 1; yr = (yr + 1) % 100; end
      end
    end
    hb = tob(hr);
    h = m12 ? {1'b1, h[6], pm, hb[4:0]} : {1'b0, h[6], hb[5:0]};
    d = {d[7:3], 3'(dw)};
    return {tob(yr), tob(mo), tob(dt), d, h, tob(mn), tob(sc), tob(hd)};
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_load(logic [63:0] img);
    @(negedge clk);
    load_valid = 1'b1;
    load_data  = img;
    model = img;
    phase = 0;
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  task automatic do_ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b1;
      if (!model[37]) begin
        phase++;
        if (phase == DIV) begin
          phase = 0;
          model = ref_step(model);
        end
      end
    end
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic do_snap(string req);
    @(negedge clk);
    exp_q.push_back(model);
    tag_q.push_back(req);
    snap_req = 1'b1;
    @(negedge clk);
    snap_req = 1'b0;
    last_snap = model;
  endtask

  // Monitor: pops the scoreboard whenever the snapshot port reports.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && snap_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R11 unexpected snap_valid", snap_data, '0);
        end else begin
          logic [63:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(snap_data === e, t, snap_data, e);
        end
      end
    end
  end

  task automatic drain();
    for (int i = 0; i < 10 && exp_q.size() != 0; i++) @(negedge clk);
    check(exp_q.size() == 0, "R11 snapshot missing", 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    model = 64'h0001_0121_0000_0000;
    phase = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(osc_run == 1'b0, "R1 osc_run", 64'(osc_run), 64'd0);
    check(rst_mask == 1'b0, "R1 rst_mask", 64'(rst_mask), 64'd0);
    check(load_ready == 1'b1, "R1 load_ready", 64'(load_ready), 64'd1);
    do_snap("R1 reset image");

    // R8 stopped clock ignores ticks
    do_ticks(20);
    do_snap("R8 stopped image frozen");

    // R2 / R9: running, mask bit set
    do_load(64'h23_06_15_13_12_34_56_78);
    check(osc_run == 1'b1, "R8 osc_run", 64'(osc_run), 64'd1);
    check(rst_mask == 1'b1, "R9 rst_mask", 64'(rst_mask), 64'd1);
    do_ticks(DIV * 3);
    do_snap("R2 hundredths advance");
    do_ticks(DIV * 25 + 2);
    do_snap("R2 seconds carry");

    // R3 / R7: 24-hour midnight at year end
    do_load(64'h99_12_31_07_23_59_59_98);
    do_ticks(DIV * 2);
    do_snap("R3 R7 year-end midnight");

    // R4: 12-hour transitions
    do_load(64'h24_03_10_02_91_59_59_99);
    do_ticks(DIV);
    do_snap("R4 11AM to 12PM");
    do_load(64'h24_03_10_02_B2_59_59_99);
    do_ticks(DIV);
    do_snap("R4 12PM to 1PM");
    do_load(64'h24_03_10_02_B1_59_59_99);
    do_ticks(DIV);
    do_snap("R4 11PM to 12AM");

    // R5 month lengths
    do_load(64'h21_04_30_01_23_59_59_99);
    do_ticks(DIV);
    do_snap("R5 April 30 rolls");
    do_load(64'h21_07_30_01_23_59_59_99);
    do_ticks(DIV);
    do_snap("R5 July 30 no roll");
    do_load(64'h21_01_31_01_23_59_59_99);
    do_ticks(DIV);
    do_snap("R5 January 31 rolls");

    // R6 leap years
    do_load(64'h24_02_28_01_23_59_59_99);
    do_ticks(DIV);
    do_snap("R6 leap 28 to 29");
    do_load(64'h23_02_28_01_23_59_59_99);
    do_ticks(DIV);
    do_snap("R6 common 28 rolls");
    do_load(64'h00_02_29_01_23_59_59_99);
    do_ticks(DIV);
    do_snap("R6 year 00 leap 29 rolls");

    // R9 control bits kept over a day step (day 7 with mask)
    do_load(64'h22_05_05_17_23_59_59_99);
    do_ticks(DIV);
    do_snap("R9 R7 day bits kept, 7 to 1");

    // R10 prescale restart on load
    do_load(64'h22_05_05_03_10_00_00_00);
    do_ticks(DIV - 1);
    do_load(64'h22_05_05_03_10_00_00_00);
    do_ticks(DIV - 1);
    do_snap("R10 phase restarted");
    do_ticks(1);
    do_snap("R10 step after full division");

    // R10 load wins over a tick in the same cycle
    do_load(64'h22_05_05_03_10_00_00_00);
    do_ticks(DIV - 1);
    @(negedge clk);
    tick_en = 1'b1; load_valid = 1'b1; load_data = 64'h22_05_05_03_10_00_00_50;
    model = 64'h22_05_05_03_10_00_00_50; phase = 0;
    @(negedge clk);
    tick_en = 1'b0; load_valid = 1'b0;
    do_snap("R10 load beats tick");

    // R11 snapshot held while clock runs across a minute
    do_load(64'h22_05_05_03_10_00_59_90);
    do_snap("R11 snapshot taken");
    drain();
    do_ticks(DIV * 20);
    check(snap_data === last_snap, "R11 snapshot held", snap_data, last_snap);
    do_snap("R11 fresh snapshot");

    drain();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule